// File: doc/BRIEF.md
# DRAM Forced Refresh Controller

This block schedules refresh for a DRAM array that is normally refreshed "hidden" between accesses, and forces a refresh when the system skipped one. A slow refresh-period clock splits time into a high phase and a low phase. During the high phase the system may refresh on its own: it holds the grant input low, and the block presents its internal row counter on the address outputs while the RAS outputs copy the RAS input. If no such refresh occurs in the high phase, the block pulls its active-low request output low when the period clock falls.

The system answers the request by driving the grant input low during the low phase, once any access in progress has finished. The block then puts the row counter on the address outputs and times one RAS pulse on every bank by counting falling edges of a separate RAS-generator clock. The request is withdrawn when that pulse begins, and the row counter advances when it ends. Releasing the grant early ends the cycle at once. Every asynchronous input is synchronized to one system clock, and edges of the two slow clocks are detected as one-cycle strobes. The request output and the counter-clear input are two pins. On the board both sit on one open-drain request/reset wire, and the clear pin senses only an external pull-down.

Top module: `refresh_forced_ctrl`

## Requirements
- R1: When no forced refresh pulse is in progress, every bit of `ras_n_o` equals `ras_in_n_i` (active low, all banks driven alike).
- R2: While `period_clk_i` is high, no forced pulse is produced, even with `grant_n_i` low and `gen_clk_i` toggling.
- R3: A hidden refresh is a falling edge of `ras_in_n_i` while `grant_n_i` is low and `period_clk_i` is high. When `period_clk_i` falls and no hidden refresh occurred since its last rise, `req_n_o` goes low. Otherwise it stays high.
- R4: The record of a hidden refresh is cleared on each rising edge of `period_clk_i`, so every high phase needs its own refresh.
- R5: `addr_o` shows the row counter while `grant_n_i` is low and shows `addr_i` while it is high.
- R6: With `period_clk_i` low, the forced pulse drives all of `ras_n_o` low on the second falling edge of `gen_clk_i` after `grant_n_i` goes low. After the first falling edge, RAS is still high.
- R7: The forced pulse returns high on the second falling edge of `gen_clk_i` after it started, and the row counter then increases by one.
- R8: `req_n_o` returns high in the same cycle that the forced pulse drives RAS low.
- R9: Raising `grant_n_i` during the forced cycle returns RAS high at once and leaves the row counter unchanged.
- R10: Holding `row_clr_n_i` low sets the row counter to zero.
- R11: The row counter increases by one at the end of each hidden refresh (rising edge of `ras_in_n_i` with `grant_n_i` low and `period_clk_i` high), and it wraps from its maximum to zero.
- R12: During reset, `ras_n_o` is all ones, `req_n_o` is high and `addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are synchronized to it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| period_clk_i | input | 1 | Refresh-period clock (one refresh expected per period) |
| gen_clk_i | input | 1 | RAS-generator clock; its falling edges time the forced pulse |
| grant_n_i | input | 1 | Active-low refresh control / grant from the system |
| ras_in_n_i | input | 1 | Active-low RAS request from the access logic |
| row_clr_n_i | input | 1 | Active-low external pull-down sensed on the request/reset wire; clears the row counter |
| addr_i | input | ROW_W | Row address from the access path |
| ras_n_o | output | NUM_BANKS | Active-low RAS, one per bank |
| req_n_o | output | 1 | Active-low forced-refresh request |
| addr_o | output | ROW_W | Registered row address: row counter or `addr_i` |

## Verification
The forced-refresh path is tried with three grant patterns in the period-clock low phase. One holds the grant through four generator-clock falls, which separates the first fall from the second (pulse start) and the third from the fourth (pulse end). One releases the grant after the pulse starts, which shows the early stop and the unchanged counter. One lowers the grant during the high phase, which shows that no pulse is forced there. Hidden refreshes in a high phase, compared with a high phase that has none, show when the request is suppressed and when it is raised. A run of 256 hidden refreshes after a counter clear drives the counter across its wrap point.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  // Positions inside the synchronized input vector
  localparam int unsigned SIG_PERIOD = 0;
  localparam int unsigned SIG_GEN    = 1;
  localparam int unsigned SIG_GRANT  = 2;
  localparam int unsigned SIG_RAS    = 3;
  localparam int unsigned SIG_CLR    = 4;
  localparam int unsigned SIG_COUNT  = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_LOW  = 2'd2,
    SEQ_HOLD = 2'd3
  } seq_state_e;

endpackage

// File: rtl/rfc_sync.sv
module rfc_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rfc_ras_seq.sv
module rfc_ras_seq #(
  parameter int unsigned LEAD_FALLS = 2,
  parameter int unsigned LOW_FALLS  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_low_i,
  input  logic period_high_i,
  input  logic gen_fall_i,
  output logic forced_o,
  output logic start_o,
  output logic finish_o
);
  import rfc_pkg::*;

  localparam int unsigned MAX_FALLS = (LEAD_FALLS > LOW_FALLS) ? LEAD_FALLS : LOW_FALLS;
  localparam int unsigned CNT_W     = $clog2(MAX_FALLS + 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_FALLS - 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_FALLS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             forced_q, forced_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    start_o  = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (grant_low_i && !period_high_i) begin
          state_d = SEQ_LEAD;
          cnt_d   = '0;
        end
      end
      SEQ_LEAD: begin
        if (!grant_low_i) begin
          state_d = SEQ_IDLE;
        end else if (gen_fall_i) begin
          if (cnt_q == LEAD_LAST) begin
            state_d = SEQ_LOW;
            cnt_d   = '0;
            start_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_LOW: begin
        if (!grant_low_i) begin
          state_d = SEQ_IDLE;
        end else if (gen_fall_i) begin
          if (cnt_q == LOW_LAST) begin
            state_d  = SEQ_HOLD;
            finish_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      SEQ_HOLD: begin
        if (!grant_low_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
    forced_d = (state_d == SEQ_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      forced_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      forced_q <= forced_d;
    end
  end

  assign forced_o = forced_q;

endmodule

// File: rtl/rfc_row_ctr.sv
module rfc_row_ctr #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_forced_i,
  input  logic             inc_hidden_i,
  output logic [ROW_W-1:0] row_o
);

  logic [ROW_W-1:0] row_q, row_d;
  logic             step;

  always_comb begin
    step  = inc_forced_i | inc_hidden_i;
    row_d = row_q;
    if (clr_i)     row_d = '0;
    else if (step) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row_o = row_q;

endmodule

// File: rtl/rfc_req.sv
module rfc_req (
  input  logic clk,
  input  logic rst_n,
  input  logic period_rise_i,
  input  logic period_fall_i,
  input  logic hidden_start_i,
  input  logic ras_start_i,
  output logic req_o
);

  logic done_q, done_d;
  logic req_q, req_d;

  always_comb begin
    done_d = done_q;
    if (period_rise_i)       done_d = 1'b0;
    else if (hidden_start_i) done_d = 1'b1;

    req_d = req_q;
    if (ras_start_i)                   req_d = 1'b0;
    else if (period_fall_i && !done_q) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      req_q  <= req_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/refresh_forced_ctrl.sv
module refresh_forced_ctrl #(
  parameter int unsigned ROW_W       = 8,
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LEAD_FALLS  = 2,
  parameter int unsigned LOW_FALLS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 period_clk_i,
  input  logic                 gen_clk_i,
  input  logic                 grant_n_i,
  input  logic                 ras_in_n_i,
  input  logic                 row_clr_n_i,
  input  logic [ROW_W-1:0]     addr_i,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic                 req_n_o,
  output logic [ROW_W-1:0]     addr_o
);
  import rfc_pkg::*;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_q = rst_pipe_q[1];

  // Input synchronization
  logic [SIG_COUNT-1:0] raw_in, sync_q;

  always_comb begin
    raw_in             = '0;
    raw_in[SIG_PERIOD] = period_clk_i;
    raw_in[SIG_GEN]    = gen_clk_i;
    raw_in[SIG_GRANT]  = grant_n_i;
    raw_in[SIG_RAS]    = ras_in_n_i;
    raw_in[SIG_CLR]    = row_clr_n_i;
  end

  rfc_sync #(
    .W       (SIG_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({SIG_COUNT{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_q),
    .d_i   (raw_in),
    .q_o   (sync_q)
  );

  // Edge strobes
  logic period_high, gen_lvl, ras_lvl_n;
  logic grant_low, clr_low;
  logic period_prev_q, gen_prev_q, ras_prev_q;
  logic period_prev_d, gen_prev_d, ras_prev_d;
  logic period_rise, period_fall, gen_fall, ras_fall, ras_rise;

  always_comb begin
    period_high   = sync_q[SIG_PERIOD];
    gen_lvl       = sync_q[SIG_GEN];
    ras_lvl_n     = sync_q[SIG_RAS];
    grant_low     = ~sync_q[SIG_GRANT];
    clr_low       = ~sync_q[SIG_CLR];
    period_prev_d = period_high;
    gen_prev_d    = gen_lvl;
    ras_prev_d    = ras_lvl_n;
    period_rise   = period_high & ~period_prev_q;
    period_fall   = ~period_high & period_prev_q;
    gen_fall      = ~gen_lvl & gen_prev_q;
    ras_fall      = ~ras_lvl_n & ras_prev_q;
    ras_rise      = ras_lvl_n & ~ras_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      period_prev_q <= 1'b1;
      gen_prev_q    <= 1'b1;
      ras_prev_q    <= 1'b1;
    end else begin
      period_prev_q <= period_prev_d;
      gen_prev_q    <= gen_prev_d;
      ras_prev_q    <= ras_prev_d;
    end
  end

  // Hidden refresh in the high phase of the period clock
  logic hidden_start, hidden_end;
  assign hidden_start = ras_fall & grant_low & period_high;
  assign hidden_end   = ras_rise & grant_low & period_high;

  // Forced RAS sequencer
  logic forced, ras_start, ras_finish;

  rfc_ras_seq #(
    .LEAD_FALLS (LEAD_FALLS),
    .LOW_FALLS  (LOW_FALLS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_q),
    .grant_low_i   (grant_low),
    .period_high_i (period_high),
    .gen_fall_i    (gen_fall),
    .forced_o      (forced),
    .start_o       (ras_start),
    .finish_o      (ras_finish)
  );

  // Row counter
  logic [ROW_W-1:0] row_cnt;

  rfc_row_ctr #(
    .ROW_W (ROW_W)
  ) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n_q),
    .clr_i        (clr_low),
    .inc_forced_i (ras_finish),
    .inc_hidden_i (hidden_end),
    .row_o        (row_cnt)
  );

  // Request logic
  logic req;

  rfc_req u_req (
    .clk            (clk),
    .rst_n          (rst_n_q),
    .period_rise_i  (period_rise),
    .period_fall_i  (period_fall),
    .hidden_start_i (hidden_start),
    .ras_start_i    (ras_start),
    .req_o          (req)
  );

  // Address mux, registered
  logic [ROW_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = grant_low ? row_cnt : addr_i;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) addr_q <= '0;
    else          addr_q <= addr_d;
  end

  // Outputs
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ras_n_o[b] = forced ? 1'b0 : ras_lvl_n;
  end

  assign req_n_o = ~req;
  assign addr_o  = addr_q;

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int unsigned ROW_W     = 8,
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 grant_low,
  input logic                 forced,
  input logic                 clr_low,
  input logic [ROW_W-1:0]     row_cnt,
  input logic [NUM_BANKS-1:0] ras_n_o,
  input logic                 req_n_o,
  input logic [ROW_W-1:0]     addr_o
);

  AST_RAS_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ras_n_o) == 0) || ($countones(ras_n_o) == NUM_BANKS)); // R1

  AST_ADDR_FROM_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    grant_low |=> (addr_o == $past(row_cnt))); // R5

  AST_REQ_OFF_AT_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(forced) |-> req_n_o); // R8

  AST_RELEASE_ENDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_low |=> !forced); // R9

  AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_low |=> (row_cnt == '0)); // R10

endmodule

bind refresh_forced_ctrl rfc_checker #(
  .ROW_W     (ROW_W),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_q),
  .grant_low (grant_low),
  .forced    (forced),
  .clr_low   (clr_low),
  .row_cnt   (row_cnt),
  .ras_n_o   (ras_n_o),
  .req_n_o   (req_n_o),
  .addr_o    (addr_o)
);

// File: tb/tb_refresh_forced_ctrl.sv
module tb_refresh_forced_ctrl;

  localparam int unsigned ROW_W = 8;
  localparam int unsigned NB    = 4;
  localparam logic [NB-1:0] ALL1 = {NB{1'b1}};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             period_clk, gen_clk, grant_n, ras_in_n, clr_n;
  logic [ROW_W-1:0] addr_in;
  logic [NB-1:0]    ras_n;
  logic             req_n;
  logic [ROW_W-1:0] addr_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  refresh_forced_ctrl #(.ROW_W(ROW_W), .NUM_BANKS(NB)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_clk_i (period_clk),
    .gen_clk_i    (gen_clk),
    .grant_n_i    (grant_n),
    .ras_in_n_i   (ras_in_n),
    .row_clr_n_i  (clr_n),
    .addr_i       (addr_in),
    .ras_n_o      (ras_n),
    .req_n_o      (req_n),
    .addr_o       (addr_out)
  );

  // {grant_n, ras_in_n, addr_i, expected ras level, expected addr_o}
  localparam int unsigned NVEC = 9;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'hA5, 1'b1, 8'hA5},
    {1'b1, 1'b0, 8'h3C, 1'b0, 8'h3C},
    {1'b1, 1'b1, 8'h3C, 1'b1, 8'h3C},
    {1'b0, 1'b1, 8'h77, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h77, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h77, 1'b1, 8'h01},
    {1'b0, 1'b0, 8'h77, 1'b0, 8'h01},
    {1'b0, 1'b1, 8'h77, 1'b1, 8'h02},
    {1'b1, 1'b1, 8'h5A, 1'b1, 8'h5A}
  };

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle;
    repeat (8) @(negedge clk);
  endtask

  task automatic gen_fall_edge;
    gen_clk = 1'b0;
    settle();
  endtask

  task automatic gen_rise_edge;
    gen_clk = 1'b1;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    period_clk = 1'b1;
    gen_clk    = 1'b1;
    grant_n    = 1'b1;
    ras_in_n   = 1'b1;
    clr_n      = 1'b1;
    addr_in    = '0;
    repeat (4) @(negedge clk);
    chk("R12 ras", 32'(ras_n), 32'(ALL1));
    chk("R12 req", 32'(req_n), 32'd1);
    chk("R12 addr", 32'(addr_out), 32'd0);
    rst_n = 1'b1;
    settle();

    // Vector table: period clock high, pass-through and hidden refresh
    for (int i = 0; i < NVEC; i++) begin
      grant_n  = VEC[i][18];
      ras_in_n = VEC[i][17];
      addr_in  = VEC[i][16:9];
      settle();
      chk("R1 ras table", 32'(ras_n), VEC[i][8] ? 32'(ALL1) : 32'd0);
      chk("R5/R11 addr table", 32'(addr_out), 32'(VEC[i][7:0]));
      chk("R3 no req in high phase", 32'(req_n), 32'd1);
    end

    // R3: hidden refresh seen in the high phase, so no request
    period_clk = 1'b0;
    settle();
    chk("R3 suppressed", 32'(req_n), 32'd1);

    // R4: new high phase without refresh, request on fall
    period_clk = 1'b1;
    settle();
    period_clk = 1'b0;
    settle();
    chk("R4 req raised", 32'(req_n), 32'd0);

    // Forced refresh, full length
    addr_in = 8'hC3;
    grant_n = 1'b0;
    settle();
    chk("R5 addr ctr", 32'(addr_out), 32'h02);
    chk("R6 no ras yet", 32'(ras_n), 32'(ALL1));
    gen_fall_edge();
    chk("R6 after fall 1", 32'(ras_n), 32'(ALL1));
    gen_rise_edge();
    gen_fall_edge();
    chk("R6 after fall 2", 32'(ras_n), 32'd0);
    chk("R8 req withdrawn", 32'(req_n), 32'd1);
    gen_rise_edge();
    gen_fall_edge();
    chk("R7 after fall 3", 32'(ras_n), 32'd0);
    gen_rise_edge();
    gen_fall_edge();
    chk("R7 after fall 4", 32'(ras_n), 32'(ALL1));
    gen_rise_edge();
    chk("R7 counter advanced", 32'(addr_out), 32'h03);
    grant_n = 1'b1;
    settle();
    chk("R5 addr pass", 32'(addr_out), 32'hC3);

    // R9: early release
    period_clk = 1'b1;
    settle();
    period_clk = 1'b0;
    settle();
    chk("R3 req again", 32'(req_n), 32'd0);
    grant_n = 1'b0;
    settle();
    gen_fall_edge();
    gen_rise_edge();
    gen_fall_edge();
    chk("R6 abort run low", 32'(ras_n), 32'd0);
    grant_n = 1'b1;
    settle();
    chk("R9 ras released", 32'(ras_n), 32'(ALL1));
    gen_rise_edge();
    grant_n = 1'b0;
    settle();
    chk("R9 counter kept", 32'(addr_out), 32'h03);
    grant_n = 1'b1;
    settle();

    // R2: grant in high phase, generator clock running
    period_clk = 1'b1;
    settle();
    grant_n = 1'b0;
    settle();
    for (int k = 0; k < 4; k++) begin
      gen_fall_edge();
      gen_rise_edge();
    end
    chk("R2 no forced ras", 32'(ras_n), 32'(ALL1));
    ras_in_n = 1'b0;
    settle();
    chk("R1 ras follows", 32'(ras_n), 32'd0);
    ras_in_n = 1'b1;
    settle();
    chk("R11 hidden inc", 32'(addr_out), 32'h04);
    grant_n = 1'b1;
    settle();

    // R10: counter clear
    clr_n = 1'b0;
    settle();
    clr_n = 1'b1;
    settle();
    grant_n = 1'b0;
    settle();
    chk("R10 cleared", 32'(addr_out), 32'h00);

    // R11: wrap
    for (int k = 0; k < 255; k++) begin
      ras_in_n = 1'b0;
      settle();
      ras_in_n = 1'b1;
      settle();
    end
    chk("R11 max", 32'(addr_out), 32'hFF);
    ras_in_n = 1'b0;
    settle();
    ras_in_n = 1'b1;
    settle();
    chk("R11 wrap", 32'(addr_out), 32'h00);
    grant_n = 1'b1;
    settle();

    // R1 in low phase without refresh; R3 suppressed after hidden refreshes
    period_clk = 1'b0;
    settle();
    chk("R3 suppressed 2", 32'(req_n), 32'd1);
    ras_in_n = 1'b0;
    settle();
    chk("R1 low phase", 32'(ras_n), 32'd0);
    ras_in_n = 1'b1;
    settle();
    chk("R1 low phase high", 32'(ras_n), 32'(ALL1));

    report();
    $finish;
  end

endmodule